// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block watches a free-running 64-bit time value and raises two interrupt-pending levels. The first, the supervisor level, is high whenever time has reached or passed a software-written supervisor compare value. The second, the guest level, does the same against its own compare value. It judges time as seen by a virtual machine, which is the raw time plus a programmable 64-bit offset, summed modulo 2^64.

Software updates each compare value through its own write strobe and 64-bit data word. The offset is a plain input and is taken fresh on every clock. Both pending outputs are registered. A change of time, offset or compare value therefore shows on the outputs exactly one clock edge later.

The pending outputs are levels, not captured events. They fall as soon as the compare value moves above the relevant time. Priority, delegation, register address decoding, privilege checks and the counter that produces time all live outside this block.

Top module: `stc_timer_cmp`

## Requirements
- R1: One clock edge after time T is applied, the supervisor pending output is 1 exactly when T >= the supervisor compare value, both taken as unsigned 64-bit numbers.
- R2: The pending outputs hold no memory of past matches. When the compare value exceeds the compared time, the output reads 0 after the next edge, even if it was 1 before.
- R3: The guest pending output compares its compare value against (time + offset) mod 2^64. The carry out of bit 63 is dropped.
- R4: Writing a compare value less than or equal to the channel's current compared time makes that channel's pending output read 1 after that same edge.
- R5: Writing a compare value greater than the channel's current compared time makes that channel's pending output read 0 after that same edge.
- R6: With a compare value of all ones, pending is 1 only while the compared time is all ones. It returns to 0 when the compared time wraps to zero.
- R7: Synchronous active-low reset clears both compare values to zero and both pending outputs to 0. After release, with compare values of zero, both outputs read 1 on the first edge.
- R8: The latency from any input change (time, offset, write) to the pending outputs is exactly one clock edge.
- R9: A write to one channel's compare value does not change the other channel's pending output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| time_i | input | 64 | Free-running time value |
| vs_offset_i | input | 64 | Offset added to time for the guest channel |
| s_cmp_we_i | input | 1 | Write strobe, supervisor compare value |
| s_cmp_wdata_i | input | 64 | Write data, supervisor compare value |
| vs_cmp_we_i | input | 1 | Write strobe, guest compare value |
| vs_cmp_wdata_i | input | 64 | Write data, guest compare value |
| s_pend_o | output | 1 | Supervisor timer pending level |
| vs_pend_o | output | 1 | Guest timer pending level |

## Verification
The bench targets the point where time equals the compare value. A design using a strict greater-than would stay low there for one tick too long.

It parks the compare value at all ones and steps time across the wrap. A design that latched the match would stay high after time returns to zero.

It chooses an offset that makes time plus offset carry out of bit 63. A design that kept the carry, or compared against raw time, would report the wrong level.

It writes compare values just below, equal to and just above the current time, and checks the following edge. This shows whether a write takes effect in the same cycle or one cycle late, and whether a write leaks into the other channel.

// File: rtl/stc_pkg.sv
// Package stc_pkg
// Shared sizing for the timer compare unit. Assumes a single clock domain
// and that all time arithmetic is unsigned and modulo 2^TIME_W.
package stc_pkg;
    parameter int unsigned TIME_W = 64;
    localparam int unsigned NUM_CH = 2;

    // Channel index: which pending level a channel drives
    typedef enum logic [0:0] {
        CH_SUPV  = 1'b0,
        CH_GUEST = 1'b1
    } chan_e;
endpackage

// File: rtl/stc_cmp_reg.sv
// Module stc_cmp_reg
// Holds one software-written compare value. Exposes both the stored value
// and the value it will hold after the current edge, so that a write is
// visible to the comparator in the same cycle. Assumes synchronous
// active-low reset to zero.
module stc_cmp_reg #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cmp_q,
    output logic [W-1:0] cmp_next
);
    // Select the value the register takes on this edge
    always_comb begin
        cmp_next = wr_en ? wr_data : cmp_q;
    end

    // Store the compare value, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_next;
        end
    end

    // R9
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cmp_q == $past(cmp_q)));
endmodule

// File: rtl/stc_offset_add.sv
// Module stc_offset_add
// Produces the compared time: raw time plus an offset, modulo 2^W. The
// carry out of the top bit is discarded on purpose. Purely combinational.
module stc_offset_add #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] time_in,
    input  logic [W-1:0] offset_in,
    output logic [W-1:0] eff_time
);
    // Wrapping add; the result width truncates the carry
    always_comb begin
        eff_time = time_in + offset_in;
    end
endmodule

// File: rtl/stc_ge_cmp.sv
// Module stc_ge_cmp
// Unsigned greater-or-equal comparison of two W-bit values, split into an
// upper and lower half to shorten the carry chain. Assumes W >= 2.
module stc_ge_cmp #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_ge_b
);
    localparam int unsigned LO_W = W / 2;
    localparam int unsigned HI_W = W - LO_W;

    logic hi_gt, hi_eq, lo_ge;

    // Compare halves independently, then merge
    always_comb begin
        hi_gt  = a[W-1:LO_W] > b[W-1:LO_W];
        hi_eq  = a[W-1:LO_W] == b[W-1:LO_W];
        lo_ge  = a[LO_W-1:0] >= b[LO_W-1:0];
        a_ge_b = hi_gt | (hi_eq & lo_ge);
    end

    // Guard against a degenerate split
    initial begin
        if (HI_W == 0 || LO_W == 0) $error("stc_ge_cmp needs W >= 2");
    end
endmodule

// File: rtl/stc_channel.sv
// Module stc_channel
// One timer compare channel: compare register, offset adder, comparator and
// the registered pending level. The pending level is recomputed every
// cycle, never latched. Assumes the caller ties offset_in to zero for a
// channel that compares raw time.
module stc_channel #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] time_in,
    input  logic [W-1:0] offset_in,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         pend_o
);
    logic [W-1:0] cmp_q, cmp_next, eff_time;
    logic         reached;
    logic         pend_q;

    stc_cmp_reg #(.W(W)) cmp_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cmp_q    (cmp_q),
        .cmp_next (cmp_next)
    );

    stc_offset_add #(.W(W)) add_i (
        .time_in   (time_in),
        .offset_in (offset_in),
        .eff_time  (eff_time)
    );

    stc_ge_cmp #(.W(W)) ge_i (
        .a      (eff_time),
        .b      (cmp_next),
        .a_ge_b (reached)
    );

    // Register the pending level one edge after its inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= reached;
        end
    end

    assign pend_o = pend_q;

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cmp_q == '0 && !pend_q));

    // R4
    past_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (time_in + offset_in) >= wr_data) |=> pend_q);

    // R5
    future_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (time_in + offset_in) < wr_data) |=> !pend_q);

    // R2
    level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (time_in + offset_in) < cmp_q) |=> !pend_q);

    // R6
    allones_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cmp_q == '1 && (time_in + offset_in) != '1) |=> !pend_q);
endmodule

// File: rtl/stc_timer_cmp.sv
// Module stc_timer_cmp
// Top of the timer compare unit: a supervisor channel comparing raw time
// and a guest channel comparing time plus offset. Assumes time_i is
// produced elsewhere in the same clock domain.
module stc_timer_cmp #(
    parameter int unsigned TIME_W = stc_pkg::TIME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_i,
    input  logic [TIME_W-1:0] vs_offset_i,
    input  logic              s_cmp_we_i,
    input  logic [TIME_W-1:0] s_cmp_wdata_i,
    input  logic              vs_cmp_we_i,
    input  logic [TIME_W-1:0] vs_cmp_wdata_i,
    output logic              s_pend_o,
    output logic              vs_pend_o
);
    import stc_pkg::*;

    logic [TIME_W-1:0] ch_off   [NUM_CH];
    logic              ch_we    [NUM_CH];
    logic [TIME_W-1:0] ch_wdata [NUM_CH];
    logic              ch_pend  [NUM_CH];

    // Route per-channel inputs; supervisor channel sees zero offset
    always_comb begin
        ch_off[CH_SUPV]    = '0;
        ch_we[CH_SUPV]     = s_cmp_we_i;
        ch_wdata[CH_SUPV]  = s_cmp_wdata_i;
        ch_off[CH_GUEST]   = vs_offset_i;
        ch_we[CH_GUEST]    = vs_cmp_we_i;
        ch_wdata[CH_GUEST] = vs_cmp_wdata_i;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        stc_channel #(.W(TIME_W)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .time_in   (time_i),
            .offset_in (ch_off[g]),
            .wr_en     (ch_we[g]),
            .wr_data   (ch_wdata[g]),
            .pend_o    (ch_pend[g])
        );
    end

    assign s_pend_o  = ch_pend[CH_SUPV];
    assign vs_pend_o = ch_pend[CH_GUEST];

    // R1
    supv_raw_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cmp_we_i && time_i >= s_cmp_wdata_i) |=> s_pend_o);
endmodule

// File: tb/stc_timer_cmp_tb_top.sv
// Bench for stc_timer_cmp: behavioural model updated each rising edge,
// outputs compared on each falling edge.
module stc_timer_cmp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tm = '0, off = '0;
    logic        swe = 1'b0, vwe = 1'b0;
    logic [63:0] swd = '0, vwd = '0;
    logic        s_pend, vs_pend;

    logic [63:0] m_s_cmp, m_vs_cmp;
    logic        e_s, e_vs;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    stc_timer_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .time_i(tm), .vs_offset_i(off),
        .s_cmp_we_i(swe), .s_cmp_wdata_i(swd),
        .vs_cmp_we_i(vwe), .vs_cmp_wdata_i(vwd),
        .s_pend_o(s_pend), .vs_pend_o(vs_pend)
    );

    task automatic check(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b (t=%0d)", tag, what, act, exp, $time);
        end
    endtask

    // One clock: model updates at the rising edge, DUT checked at the falling one
    task automatic step(string tag);
        logic [63:0] vt;
        @(posedge clk);
        if (!rst_n) begin
            m_s_cmp = '0; m_vs_cmp = '0; e_s = 1'b0; e_vs = 1'b0;
        end else begin
            if (swe) m_s_cmp = swd;
            if (vwe) m_vs_cmp = vwd;
            vt   = tm + off;
            e_s  = (tm >= m_s_cmp);
            e_vs = (vt >= m_vs_cmp);
        end
        @(negedge clk);
        check(tag, "s_pend", s_pend, e_s);
        check(tag, "vs_pend", vs_pend, e_vs);
        swe = 1'b0;
        vwe = 1'b0;
    endtask

    task automatic wr_s(logic [63:0] v);
        swe = 1'b1; swd = v;
    endtask

    task automatic wr_vs(logic [63:0] v);
        vwe = 1'b1; vwd = v;
    endtask

    initial begin
        @(negedge clk);
        // R7: held in reset, outputs low
        repeat (3) step("R7");
        rst_n = 1'b1;
        // R7: compare values zero, time zero -> both pending
        step("R7");
        // R5 / R9: supervisor write above time clears only supervisor level
        tm = 64'd10; wr_s(64'd100);
        step("R5_R9");
        // R8: exactly one edge later, still matches model
        step("R8");
        // R1: walk time up to the compare value
        for (int i = 97; i <= 101; i++) begin
            tm = 64'(i);
            step("R1");
        end
        // R4: write a value in the past
        wr_s(64'd50);
        step("R4");
        // R2: level falls when compare moves above time
        wr_s(64'd200);
        step("R2");
        // R4: write equal to current time
        wr_s(tm);
        step("R4");
        // R3: guest channel against time + offset
        off = 64'd1000; wr_vs(64'd1050);
        step("R3_R4");
        wr_vs(64'd1200);
        step("R3_R5");
        tm = 64'd199; step("R3");
        tm = 64'd200; step("R3");
        // R8: offset change alone shows one edge later
        off = 64'd0; step("R8");
        // R3: wrapping sum, carry dropped
        off = 64'hFFFF_FFFF_FFFF_FFCE; // -50
        wr_vs(64'd20); tm = 64'd60;    // eff 10
        step("R3");
        tm = 64'd69; step("R3");       // eff 19
        tm = 64'd70; step("R3");       // eff 20
        tm = 64'd40; step("R3");       // eff huge
        // R6: all-ones compare across the wrap, supervisor
        wr_s('1); tm = 64'hFFFF_FFFF_FFFF_FFFD;
        step("R6");
        tm = 64'hFFFF_FFFF_FFFF_FFFE; step("R6");
        tm = '1;                      step("R6");
        tm = '0;                      step("R6");
        tm = 64'd1;                   step("R6");
        // R6: guest channel all ones, offset-driven wrap
        off = 64'd5; wr_vs('1); tm = 64'hFFFF_FFFF_FFFF_FFFA;
        step("R6");
        tm = 64'hFFFF_FFFF_FFFF_FFFB; step("R6");
        // R9: guest write leaves supervisor untouched
        tm = 64'd300; wr_s(64'd300); step("R9");
        wr_vs(64'd5); step("R9");
        wr_vs('1); step("R9");
        // R7: mid-run reset
        rst_n = 1'b0; step("R7");
        rst_n = 1'b1; tm = 64'd7; step("R7");
        // R1: mixed stimulus near the compare values
        for (int i = 0; i < 300; i++) begin
            logic [63:0] base;
            base = {$urandom(), $urandom()};
            tm  = base;
            off = ($urandom_range(0, 3) == 0) ? {$urandom(), $urandom()} : 64'(($urandom_range(0, 4)));
            if ($urandom_range(0, 2) == 0) wr_s(base + 64'($urandom_range(0, 4)) - 64'd2);
            if ($urandom_range(0, 2) == 0) wr_vs(base + off + 64'($urandom_range(0, 4)) - 64'd2);
            step("R1");
            tm = tm + 64'd1; step("R1");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule